// File: doc/BRIEF.md
# Task-Driven Compare Timer

A free-running counter controlled entirely through write-triggered task registers on a simple word-addressed 32-bit register bus. One write starts counting, one stops it and one zeroes it. A clock-enable input `tick` stands for the base counting rate. The counter advances only on cycles where `tick` is high, divided further by a power-of-two prescaler. A width selector makes the counter wrap at 8, 16, 24 or 32 bits.

Four compare channels each hold a 32-bit value. A channel raises its own sticky event when the counter steps onto that value. The event stays set until software writes zero to the channel's event register. The events are also brought out as a 4-bit vector for neighbouring logic. A compare value behind the current count therefore fires only after the counter has wrapped.

Top module: `tmr_task_timer`

## Requirements
- R1: After reset the timer is stopped with count 0 and prescale phase 0. The width selector reads 0 (16-bit), the prescaler reads 0, every compare value reads 0 and every event reads 0.
- R2: A write of exactly 1 triggers a task: word 0 starts counting, word 1 stops counting and holds the count, and word 2 zeroes the count and the prescale phase. A write of any other value to these words is ignored, and reading them returns 0.
- R3: Word 3 bits [1:0] select the counter width: 0 gives 16 bits, 1 gives 8 bits, 2 gives 24 bits and 3 gives 32 bits. The counter steps from the all-ones value of that width to 0.
- R4: Word 4 bits [3:0] hold the prescaler p. While running, the counter advances once per 2^p cycles with `tick` high, so p = 0 advances on every tick. Values above 9 act as 9.
- R5: Compare values live at words 8 to 11 (channels 0 to 3), and events at words 12 to 15. An event reads 1 in bit 0, and drives `cmp_event[i]` high, from the edge at which the counter steps onto a value equal to that channel's compare value.
- R6: An event stays set until a write of 0 to its word. Non-zero writes to an event word are ignored. A hardware set on the same edge as a clearing write wins.
- R7: A compare value below the current count fires only after a wrap. A value above the selected width's maximum never fires. Zeroing the count with the clear task does not fire a channel whose compare value is 0.
- R8: A start after a stop resumes from the held count, so the first step after the start reaches the held count plus one.
- R9: Words 5, 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base-rate count enable |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cmp_event | output | 4 | Sticky compare events, one per channel |

## Verification
The count itself is not readable, so a wrong count, prescale phase or run flag shows up only when a channel fires on the wrong edge. It can also show as a channel not firing at all, possibly one wrap later, some 2^16 ticks after the fault. The bench therefore places compare values one step either side of the expected count, so that an off-by-one in the step, the wrap or the prescale limit changes an event within one counter step. An event clearing or setting without cause shows on `cmp_event` on the very next edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 32;
    localparam int PSC_W   = 4;
    localparam int PSC_MAX = 9;

    typedef enum logic [1:0] {
        WM_16 = 2'd0,
        WM_8  = 2'd1,
        WM_24 = 2'd2,
        WM_32 = 2'd3
    } width_mode_e;

    // word map
    localparam logic [ADDR_W-1:0] A_RUN  = 4'd0;
    localparam logic [ADDR_W-1:0] A_HALT = 4'd1;
    localparam logic [ADDR_W-1:0] A_ZERO = 4'd2;
    localparam logic [ADDR_W-1:0] A_MODE = 4'd3;
    localparam logic [ADDR_W-1:0] A_PSC  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CC0  = 4'd8;
    localparam logic [ADDR_W-1:0] A_EVT0 = 4'd12;

    function automatic logic [CNT_W-1:0] width_mask(width_mode_e m);
        case (m)
            WM_8:    return 32'h0000_00FF;
            WM_24:   return 32'h00FF_FFFF;
            WM_32:   return 32'hFFFF_FFFF;
            default: return 32'h0000_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int SEL_W   = PSC_W,
    parameter int SEL_MAX = PSC_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic [SEL_W-1:0] psc,
    output logic             step
);
    localparam int DIV_W = SEL_MAX + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [SEL_W-1:0] eff;
    logic [DIV_W-1:0] limit;
    logic             at_limit;

    always_comb begin
        eff      = (psc > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : psc;
        limit    = (DIV_W'(1) << eff) - DIV_W'(1);
        // >= keeps a phase left over from a larger divider from running long
        at_limit = (st_q.div >= limit);
        step     = run && tick && at_limit;
        st_d     = st_q;
        if (restart) begin
            st_d.div = '0;
        end else if (run && tick) begin
            st_d.div = at_limit ? '0 : st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    input  logic        zero,
    input  width_mode_e mode,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t   st_d, st_q;
    logic [W-1:0] mask;

    always_comb begin
        mask    = W'(width_mask(mode));
        cnt_nxt = (st_q.cnt + W'(1)) & mask;
        st_d    = st_q;
        if (zero)      st_d.cnt = '0;
        else if (step) st_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cc_we,
    input  logic         evt_we,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic [W-1:0] cnt_nxt,
    output logic [W-1:0] cc_q,
    output logic         evt_q
);
    typedef struct packed {
        logic [W-1:0] cc;
        logic         evt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit  = step && (st_q.cc == cnt_nxt);
        st_d = st_q;
        if (cc_we) st_d.cc = wdata;
        if (hit)                            st_d.evt = 1'b1;
        else if (evt_we && (wdata == '0))   st_d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cc_q  = st_q.cc;
    assign evt_q = st_q.evt;
endmodule

// File: rtl/tmr_task_timer.sv
`timescale 1ns/1ps
module tmr_task_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] cmp_event
);
    typedef struct packed {
        logic             run;
        width_mode_e      mode;
        logic [PSC_W-1:0] psc;
    } ctl_state_t;

    ctl_state_t        st_d, st_q;
    logic              do_run, do_halt, do_zero;
    logic              cnt_step;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic [DATA_W-1:0] cc_vals [NUM_CH];
    logic [NUM_CH-1:0] evt_vec;
    logic              run_q;
    width_mode_e       mode_q;
    logic [PSC_W-1:0]  psc_q;

    always_comb begin
        do_run  = bus_we && (bus_addr == A_RUN)  && (bus_wdata == DATA_W'(1));
        do_halt = bus_we && (bus_addr == A_HALT) && (bus_wdata == DATA_W'(1));
        do_zero = bus_we && (bus_addr == A_ZERO) && (bus_wdata == DATA_W'(1));
        st_d    = st_q;
        if (do_run)  st_d.run = 1'b1;
        if (do_halt) st_d.run = 1'b0;
        if (bus_we && (bus_addr == A_MODE)) st_d.mode = width_mode_e'(bus_wdata[1:0]);
        if (bus_we && (bus_addr == A_PSC))  st_d.psc  = bus_wdata[PSC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: 1'b0, mode: WM_16, psc: '0};
        else        st_q <= st_d;
    end

    assign run_q  = st_q.run;
    assign mode_q = st_q.mode;
    assign psc_q  = st_q.psc;

    tmr_prescaler #(.SEL_W(PSC_W), .SEL_MAX(PSC_MAX)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .tick    (tick),
        .restart (do_zero),
        .psc     (st_q.psc),
        .step    (cnt_step)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (cnt_step),
        .zero    (do_zero),
        .mode    (st_q.mode),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_channel #(.W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cc_we   (bus_we && (bus_addr == (A_CC0 + ADDR_W'(g)))),
            .evt_we  (bus_we && (bus_addr == (A_EVT0 + ADDR_W'(g)))),
            .wdata   (bus_wdata),
            .step    (cnt_step),
            .cnt_nxt (cnt_nxt),
            .cc_q    (cc_vals[g]),
            .evt_q   (evt_vec[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MODE) bus_rdata = DATA_W'(st_q.mode);
        if (bus_addr == A_PSC)  bus_rdata = DATA_W'(st_q.psc);
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == (A_CC0 + ADDR_W'(i)))  bus_rdata = cc_vals[i];
            if (bus_addr == (A_EVT0 + ADDR_W'(i))) bus_rdata = DATA_W'(evt_vec[i]);
        end
    end

    assign cmp_event = evt_vec;
endmodule

// File: rtl/tmr_task_timer_chk.sv
`timescale 1ns/1ps
module tmr_task_timer_chk
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] cmp_event,
    input logic              run,
    input logic              step,
    input logic [CNT_W-1:0]  cnt,
    input width_mode_e       mode,
    input logic [PSC_W-1:0]  psc
);
    logic             zero_wr;
    logic             psc_wr;
    logic [CNT_W-1:0] lim;

    assign zero_wr = bus_we && (bus_addr == A_ZERO) && (bus_wdata == DATA_W'(1));
    assign psc_wr  = bus_we && (bus_addr == A_PSC);
    assign lim     = width_mask(mode);

    p_task_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr <= A_ZERO) |-> (bus_rdata == '0));

    p_stop_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !zero_wr) |=> $stable(cnt));

    p_zero_task_r2: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> (cnt == '0));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cnt == lim)) |=> (cnt == '0));

    p_count_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cnt < lim) && !zero_wr) |=> (cnt == $past(cnt) + 1));

    p_every_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && (psc == '0)) |-> step);

    p_divided_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (psc != '0) && !psc_wr) |=> !step);

    p_hole_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr > A_PSC) && (bus_addr < A_CC0)) |-> (bus_rdata == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_evt
        p_evt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cmp_event[g]) |-> $past(step));

        p_evt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cmp_event[g]) |->
                $past(bus_we && (bus_addr == (A_EVT0 + ADDR_W'(g))) && (bus_wdata == '0)));
    end
endmodule

bind tmr_task_timer tmr_task_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmp_event (cmp_event),
    .run       (run_q),
    .step      (cnt_step),
    .cnt       (cnt_q),
    .mode      (mode_q),
    .psc       (psc_q)
);

// File: tb/tmr_task_timer_tb.sv
`timescale 1ns/1ps
module tmr_task_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cmp_event;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    tmr_task_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cmp_event(cmp_event)
    );

    // ---------------- reference model from the requirements ----------------
    logic        m_run;
    logic [1:0]  m_mode;
    logic [3:0]  m_psc;
    int unsigned m_pre;
    logic [31:0] m_cnt;
    logic [31:0] m_cc [4];
    logic [3:0]  m_evt;
    logic        m_stp;
    logic [31:0] m_nc;
    logic [3:0]  m_hit;
    int unsigned m_lim;

    function automatic logic [31:0] bmask(input logic [1:0] m);   // R3
        case (m)
            2'd1:    return 32'hFF;
            2'd2:    return 32'hFF_FFFF;
            2'd3:    return 32'hFFFF_FFFF;
            default: return 32'hFFFF;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_mode = 0; m_psc = 0; m_pre = 0; m_cnt = 0; m_evt = 0;
            for (int c = 0; c < 4; c++) m_cc[c] = 0;
        end else begin
            m_lim = (32'd1 << ((m_psc > 4'd9) ? 9 : m_psc)) - 1;
            m_stp = 0;
            if (m_run && tick) begin
                if (m_pre >= m_lim) begin m_pre = 0; m_stp = 1; end
                else m_pre = m_pre + 1;
            end
            m_nc = (m_cnt + 1) & bmask(m_mode);
            for (int c = 0; c < 4; c++) m_hit[c] = m_stp && (m_cc[c] == m_nc);
            if (m_stp) m_cnt = m_nc;
            if (bus_we) begin
                case (bus_addr)
                    4'd0: if (bus_wdata == 32'd1) m_run = 1;
                    4'd1: if (bus_wdata == 32'd1) m_run = 0;
                    4'd2: if (bus_wdata == 32'd1) begin m_cnt = 0; m_pre = 0; end
                    4'd3: m_mode = bus_wdata[1:0];
                    4'd4: m_psc = bus_wdata[3:0];
                    4'd8, 4'd9, 4'd10, 4'd11: m_cc[bus_addr - 4'd8] = bus_wdata;
                    4'd12, 4'd13, 4'd14, 4'd15:
                        if (bus_wdata == 32'd0) m_evt[bus_addr - 4'd12] = 1'b0;
                    default: ;
                endcase
            end
            m_evt = m_evt | m_hit;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_we = 0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1;
        end
        @(negedge clk);
        tick = 0;
    endtask

    task automatic clr_evts();
        for (int c = 0; c < 4; c++) wr(4'd12 + 4'(c), 32'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd_chk(4'd3, 32'd0, "R1 mode");
        rd_chk(4'd4, 32'd0, "R1 psc");
        for (int c = 0; c < 4; c++) rd_chk(4'd8 + 4'(c), 32'd0, "R1 cc");
        for (int c = 0; c < 4; c++) rd_chk(4'd12 + 4'(c), 32'd0, "R1 evt");
        chk("R1 cmp_event", {28'd0, cmp_event}, 32'd0);

        // R9: hole words
        wr(4'd5, 32'hDEAD_BEEF);
        wr(4'd6, 32'd1);
        rd_chk(4'd5, 32'd0, "R9 word5");
        rd_chk(4'd7, 32'd0, "R9 word7");
        // R2: task words read 0
        wr(4'd1, 32'd1);
        rd_chk(4'd0, 32'd0, "R2 read start");
        rd_chk(4'd2, 32'd0, "R2 read clear");

        // R5: basic compares in 16-bit mode, prescaler 0
        wr(4'd8, 32'd2); wr(4'd9, 32'd162); wr(4'd10, 32'd480); wr(4'd11, 32'h12345);
        wr(4'd0, 32'd1);
        ticks(1);   chk("R5 before cc0", {28'd0, cmp_event}, 32'h0);
        ticks(1);   chk("R5 cc0 hit",    {28'd0, cmp_event}, 32'h1);
        ticks(159); chk("R5 before cc1", {28'd0, cmp_event}, 32'h1);
        ticks(1);   chk("R5 cc1 hit",    {28'd0, cmp_event}, 32'h3);
        ticks(317); chk("R5 before cc2", {28'd0, cmp_event}, 32'h3);
        ticks(1);   chk("R5 cc2 hit",    {28'd0, cmp_event}, 32'h7);
        rd_chk(4'd12, 32'd1, "R5 evt0 read");
        rd_chk(4'd15, 32'd0, "R5 evt3 read");

        // R6: sticky events
        wr(4'd12, 32'd7);
        rd_chk(4'd12, 32'd1, "R6 nonzero write ignored");
        wr(4'd12, 32'd0);
        rd_chk(4'd12, 32'd0, "R6 zero write clears");
        chk("R6 cmp_event after clear", {28'd0, cmp_event}, 32'h6);

        // R2 / R8: stop holds, bad trigger ignored, start resumes
        wr(4'd1, 32'd1);
        clr_evts();
        wr(4'd11, 32'd481);
        ticks(50);  chk("R2 stopped no event", {28'd0, cmp_event}, 32'h0);
        wr(4'd0, 32'd2);
        ticks(5);   chk("R2 start value 2 ignored", {28'd0, cmp_event}, 32'h0);
        wr(4'd0, 32'd1);
        ticks(1);   chk("R8 resume from held count", {28'd0, cmp_event}, 32'h8);

        // R7 / R3: 8-bit wrap, late compare, out-of-range compare, clear with cc=0
        wr(4'd1, 32'd1);
        wr(4'd8, 32'd0); wr(4'd9, 32'd300);
        clr_evts();
        wr(4'd3, 32'd1);
        wr(4'd2, 32'd1);
        chk("R7 clear does not fire cc=0", {28'd0, cmp_event}, 32'h0);
        wr(4'd0, 32'd1);
        ticks(100);
        wr(4'd10, 32'd40);
        ticks(155); chk("R7 late compare waits", {28'd0, cmp_event}, 32'h0);
        ticks(1);   chk("R3 8-bit wrap to 0", {28'd0, cmp_event}, 32'h1);
        ticks(40);  chk("R7 late compare after wrap", {28'd0, cmp_event}, 32'h5);

        // R3: 16-bit wrap
        wr(4'd1, 32'd1); wr(4'd2, 32'd1); clr_evts();
        wr(4'd3, 32'd0);
        wr(4'd8, 32'hFFFF); wr(4'd9, 32'd0); wr(4'd10, 32'h10000); wr(4'd11, 32'h20000);
        wr(4'd0, 32'd1);
        ticks(65534); chk("R3 16-bit before max", {28'd0, cmp_event}, 32'h0);
        ticks(1);     chk("R3 16-bit max", {28'd0, cmp_event}, 32'h1);
        ticks(1);     chk("R3 16-bit wrap", {28'd0, cmp_event}, 32'h3);

        // R3: 24-bit passes 0xFFFF without wrapping
        wr(4'd1, 32'd1); wr(4'd2, 32'd1); clr_evts();
        wr(4'd3, 32'd2);
        wr(4'd8, 32'h10000); wr(4'd9, 32'hFFFF); wr(4'd10, 32'h100_0000);
        wr(4'd0, 32'd1);
        ticks(65536); chk("R3 24-bit past 16 bits", {28'd0, cmp_event}, 32'h3);
        rd_chk(4'd3, 32'd2, "R3 mode readback");

        // R4: prescaler 3 and clamped 12
        wr(4'd1, 32'd1); wr(4'd2, 32'd1); clr_evts();
        wr(4'd3, 32'd1);
        wr(4'd8, 32'd2); wr(4'd9, 32'd1);
        wr(4'd4, 32'd3);
        wr(4'd0, 32'd1);
        ticks(7);  chk("R4 p=3 before first step", {28'd0, cmp_event}, 32'h0);
        ticks(1);  chk("R4 p=3 first step", {28'd0, cmp_event}, 32'h2);
        ticks(7);  chk("R4 p=3 before second step", {28'd0, cmp_event}, 32'h2);
        ticks(1);  chk("R4 p=3 second step", {28'd0, cmp_event}, 32'h3);
        wr(4'd1, 32'd1); wr(4'd2, 32'd1); clr_evts();
        wr(4'd4, 32'd12);
        rd_chk(4'd4, 32'd12, "R4 psc readback");
        wr(4'd0, 32'd1);
        ticks(511); chk("R4 p=12 acts as 9, before", {28'd0, cmp_event}, 32'h0);
        ticks(1);   chk("R4 p=12 acts as 9, step", {28'd0, cmp_event}, 32'h2);

        // Random mix against the model (R5, R6, R2, R4)
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk("R5 R6 random events", {28'd0, cmp_event}, {28'd0, m_evt});
            tick     = ($urandom % 4) != 0;
            bus_we   = ($urandom % 3) == 0;
            bus_addr = 4'($urandom % 16);
            case (bus_addr)
                4'd0, 4'd1, 4'd2: bus_wdata = $urandom % 3;
                4'd3:             bus_wdata = $urandom % 4;
                4'd4:             bus_wdata = $urandom % 3;
                4'd8, 4'd9, 4'd10, 4'd11: bus_wdata = $urandom % 64;
                4'd12, 4'd13, 4'd14, 4'd15:
                    bus_wdata = (($urandom % 2) == 0) ? 32'd0 : $urandom;
                default:          bus_wdata = $urandom;
            endcase
        end
        @(negedge clk);
        bus_we = 0; tick = 0;
        @(negedge clk);
        chk("R6 final events", {28'd0, cmp_event}, {28'd0, m_evt});
        rd_chk(4'd3, {30'd0, m_mode}, "R3 final mode");
        rd_chk(4'd4, {28'd0, m_psc}, "R4 final psc");
        for (int c = 0; c < 4; c++) rd_chk(4'd8 + 4'(c), m_cc[c], "R5 final cc");
        rd_chk(4'd6, 32'd0, "R9 final hole");

        done = 1;
        summary();
        $finish;
    end
endmodule